// File: doc/BRIEF.md
# Lockable watchdog control register

This block is the 8-bit control register that sits in front of a watchdog timer. The register lives in the bus clock domain and holds three control bits: a run bit, a window-mode bit and a sticky always-on bit. Each bit has its own write-permission rule. Once the always-on bit is set it can only be cleared by power-on reset. While it is set, the run bit is frozen, the watchdog is forced to run, and a lock output tells the neighbouring configuration registers to refuse writes.

Changes to the run bit reach a slower watchdog clock domain through a toggle request and acknowledge handshake. A busy flag is shown for the whole round trip. The window-mode and always-on levels are passed into the watchdog domain through plain level synchronizers. At power-on reset, three startup-value inputs set the initial contents in both domains.

Top module: `wdog_ctl_lock`

## Requirements
- R1: While `por` is high, the register loads bit 7 from `boot_aon`, bit 2 from `boot_win` and bit 1 from `boot_en`. `busy` is 0, `wd_enable` equals `boot_en | boot_aon` and `wd_window` equals `boot_win`.
- R2: A write with bit 7 set makes the always-on bit 1. Later writes with bit 7 clear leave it at 1. Only `por` clears it.
- R3: Bits 6:3 and bit 0 of `rd_data` always read 0, whatever is written to them.
- R4: The run bit (bit 1) is writable only while the always-on bit is 0. While always-on is 1, `wd_enable` is 1 even when the stored run bit is 0.
- R5: The window bit (bit 2) is written only if the stored run bit is 0 or the always-on bit is 1 in the cycle of the write. Otherwise the write leaves it unchanged.
- R6: An accepted write that changes the run bit shows the new value on `rd_data[1]` and raises `busy` one bus cycle after the write. `busy` falls only after `wd_enable` has taken the new value.
- R7: A write to the run bit while `busy` is 1 is ignored.
- R8: `cfg_lock` equals the always-on bit. `wd_window` follows the window bit after synchronization into the watchdog domain.
- R9: A write whose bit 1 equals the stored run bit does not raise `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register access clock |
| wd_clk | input | 1 | Watchdog domain clock |
| por | input | 1 | Synchronous active-high power-on reset, used in both domains |
| boot_aon | input | 1 | Startup value of the always-on bit |
| boot_win | input | 1 | Startup value of the window bit |
| boot_en | input | 1 | Startup value of the run bit |
| wr_en | input | 1 | Write strobe, one bus cycle |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current register contents |
| busy | output | 1 | Run-bit transfer in progress |
| cfg_lock | output | 1 | Write lock for the sibling configuration registers |
| wd_enable | output | 1 | Effective watchdog run level, watchdog domain |
| wd_window | output | 1 | Window-mode level, watchdog domain |

## Verification
The permission logic is driven with write values under each combination of stored run bit, always-on bit and busy state. This separates a blocked write from an accepted one, and an accepted write that changes the run bit from one that does not. A write arriving mid-handshake shows whether the request toggle is protected. An all-ones write shows whether reserved bits leak into the register. Resetting first with non-zero startup values and then with zeros shows that both domains load the startup inputs and that only reset clears the sticky bit.

// File: rtl/wdc_pkg.sv
package wdc_pkg;
  localparam int REG_W   = 8;
  localparam int AON_BIT = 7;
  localparam int WIN_BIT = 2;
  localparam int EN_BIT  = 1;
  localparam logic [REG_W-1:0] LIVE_MASK =
    REG_W'((1 << AON_BIT) | (1 << WIN_BIT) | (1 << EN_BIT));
  localparam logic [REG_W-1:0] RSVD_MASK = ~LIVE_MASK;
endpackage

// File: rtl/wdc_sync.sv
module wdc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rst_val,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{rst_val}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/wdc_bus_regs.sv
module wdc_bus_regs
  import wdc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             boot_aon,
  input  logic             boot_win,
  input  logic             boot_en,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             ack_sync,
  output logic             aon_q,
  output logic             win_q,
  output logic             en_q,
  output logic             req_tgl,
  output logic             busy
);
  logic en_take;
  logic win_take;

  assign busy     = req_tgl ^ ack_sync;
  assign en_take  = wr_en && !aon_q && !busy && (wr_data[EN_BIT] != en_q);
  assign win_take = wr_en && (!en_q || aon_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      aon_q   <= boot_aon;
      win_q   <= boot_win;
      en_q    <= boot_en;
      req_tgl <= 1'b0;
    end else begin
      if (wr_en)    aon_q <= aon_q | wr_data[AON_BIT];
      if (win_take) win_q <= wr_data[WIN_BIT];
      if (en_take) begin
        en_q    <= wr_data[EN_BIT];
        req_tgl <= ~req_tgl;
      end
    end
  end
endmodule

// File: rtl/wdc_wd_side.sv
module wdc_wd_side (
  input  logic clk,
  input  logic rst,
  input  logic boot_en,
  input  logic req_sync,
  input  logic en_level,
  output logic wd_en_q,
  output logic ack_tgl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wd_en_q <= boot_en;
      ack_tgl <= 1'b0;
    end else if (req_sync != ack_tgl) begin
      wd_en_q <= en_level;
      ack_tgl <= req_sync;
    end
  end
endmodule

// File: rtl/wdog_ctl_lock.sv
module wdog_ctl_lock
  import wdc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             bus_clk,
  input  logic             wd_clk,
  input  logic             por,
  input  logic             boot_aon,
  input  logic             boot_win,
  input  logic             boot_en,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             busy,
  output logic             cfg_lock,
  output logic             wd_enable,
  output logic             wd_window
);
  logic aon_q, win_q, en_q, req_tgl, ack_tgl, ack_sync, req_sync;
  logic aon_wd, wd_en_q;

  wdc_bus_regs u_regs (
    .clk(bus_clk), .rst(por),
    .boot_aon(boot_aon), .boot_win(boot_win), .boot_en(boot_en),
    .wr_en(wr_en), .wr_data(wr_data), .ack_sync(ack_sync),
    .aon_q(aon_q), .win_q(win_q), .en_q(en_q),
    .req_tgl(req_tgl), .busy(busy)
  );

  wdc_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(wd_clk), .rst(por), .rst_val(1'b0), .d(req_tgl), .q(req_sync)
  );

  wdc_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(bus_clk), .rst(por), .rst_val(1'b0), .d(ack_tgl), .q(ack_sync)
  );

  wdc_sync #(.STAGES(SYNC_STAGES)) u_aon_sync (
    .clk(wd_clk), .rst(por), .rst_val(boot_aon), .d(aon_q), .q(aon_wd)
  );

  wdc_sync #(.STAGES(SYNC_STAGES)) u_win_sync (
    .clk(wd_clk), .rst(por), .rst_val(boot_win), .d(win_q), .q(wd_window)
  );

  wdc_wd_side u_wd (
    .clk(wd_clk), .rst(por), .boot_en(boot_en),
    .req_sync(req_sync), .en_level(en_q),
    .wd_en_q(wd_en_q), .ack_tgl(ack_tgl)
  );

  always_comb begin
    rd_data          = '0;
    rd_data[AON_BIT] = aon_q;
    rd_data[WIN_BIT] = win_q;
    rd_data[EN_BIT]  = en_q;
  end

  assign cfg_lock  = aon_q;
  assign wd_enable = wd_en_q | aon_wd;
endmodule

// File: rtl/wdc_ctl_checker.sv
module wdc_ctl_checker
  import wdc_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [REG_W-1:0] rd_data,
  input logic             busy
);
  a_r2_aon_sticky: assert property (@(posedge clk) disable iff (rst)
    rd_data[AON_BIT] |=> rd_data[AON_BIT]);

  a_r3_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_data & RSVD_MASK) == '0);

  a_r4_en_frozen: assert property (@(posedge clk) disable iff (rst)
    rd_data[AON_BIT] |=> $stable(rd_data[EN_BIT]));

  a_r5_win_guard: assert property (@(posedge clk) disable iff (rst)
    (rd_data[EN_BIT] && !rd_data[AON_BIT]) |=> $stable(rd_data[WIN_BIT]));

  a_r7_busy_hold: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(rd_data[EN_BIT]));

  a_r6_busy_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(wr_en) && !$stable(rd_data[EN_BIT])));
endmodule

bind wdog_ctl_lock wdc_ctl_checker u_chk (
  .clk(bus_clk), .rst(por), .wr_en(wr_en), .rd_data(rd_data), .busy(busy)
);

// File: tb/wdog_ctl_lock_tb.sv
module wdog_ctl_lock_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_PERIOD  = 30;

  logic bus_clk = 1'b0, wd_clk = 1'b0, por = 1'b1;
  logic boot_aon = 1'b0, boot_win = 1'b0, boot_en = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic busy, cfg_lock, wd_enable, wd_window;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) bus_clk = ~bus_clk;
  always #(WD_PERIOD/2)  wd_clk  = ~wd_clk;

  wdog_ctl_lock u_dut (
    .bus_clk(bus_clk), .wd_clk(wd_clk), .por(por),
    .boot_aon(boot_aon), .boot_win(boot_win), .boot_en(boot_en),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .busy(busy), .cfg_lock(cfg_lock),
    .wd_enable(wd_enable), .wd_window(wd_window)
  );

  task automatic chk(input string what, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic do_reset(input logic a, input logic w, input logic e);
    @(negedge bus_clk);
    por = 1'b1; boot_aon = a; boot_win = w; boot_en = e;
    repeat (4) @(posedge wd_clk);
    @(negedge bus_clk);
    por = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge bus_clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge bus_clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) @(negedge bus_clk);
    @(negedge bus_clk);
  endtask

  task automatic wd_settle();
    repeat (4) @(posedge wd_clk);
    @(negedge bus_clk);
  endtask

  task automatic t_reset_values();
    do_reset(1'b0, 1'b1, 1'b1);
    @(negedge bus_clk);
    chk("R1 rd_data after reset", rd_data, 8'h06);
    chk("R1 busy after reset", {7'b0, busy}, 8'h00);
    chk("R1 wd_enable after reset", {7'b0, wd_enable}, 8'h01);
    chk("R1 wd_window after reset", {7'b0, wd_window}, 8'h01);
    do_reset(1'b0, 1'b0, 1'b0);
    @(negedge bus_clk);
    chk("R1 rd_data zero boot", rd_data, 8'h00);
    chk("R1 wd_enable zero boot", {7'b0, wd_enable}, 8'h00);
  endtask

  task automatic t_enable_handshake();
    do_write(8'h02);
    chk("R6 enable readback", rd_data, 8'h02);
    chk("R6 busy raised", {7'b0, busy}, 8'h01);
    wait_idle();
    chk("R6 busy cleared", {7'b0, busy}, 8'h00);
    chk("R6 wd_enable took value", {7'b0, wd_enable}, 8'h01);
  endtask

  task automatic t_busy_ignore();
    do_write(8'h00);
    chk("R7 first write accepted", rd_data, 8'h00);
    do_write(8'h02);
    chk("R7 write during busy ignored", rd_data, 8'h00);
    wait_idle();
    chk("R7 wd_enable stays off", {7'b0, wd_enable}, 8'h00);
    do_write(8'h02);
    wait_idle();
    chk("R7 enable back on", {7'b0, wd_enable}, 8'h01);
  endtask

  task automatic t_window_guard();
    do_write(8'h06);
    chk("R9 same enable no busy", {7'b0, busy}, 8'h00);
    chk("R5 window blocked while enabled", rd_data, 8'h02);
    do_write(8'h00);
    wait_idle();
    do_write(8'h04);
    chk("R5 window written while disabled", rd_data, 8'h04);
    chk("R9 no busy on window write", {7'b0, busy}, 8'h00);
    wd_settle();
    chk("R8 wd_window follows", {7'b0, wd_window}, 8'h01);
  endtask

  task automatic t_always_on();
    do_write(8'h84);
    chk("R2 always-on set", rd_data, 8'h84);
    chk("R8 cfg_lock high", {7'b0, cfg_lock}, 8'h01);
    wd_settle();
    chk("R4 wd_enable forced", {7'b0, wd_enable}, 8'h01);
    do_write(8'h86);
    chk("R4 enable frozen", rd_data, 8'h84);
    chk("R4 no busy when locked", {7'b0, busy}, 8'h00);
    do_write(8'h00);
    chk("R2 zero write keeps bit, R5 window open", rd_data, 8'h80);
    do_write(8'hFF);
    chk("R3 reserved bits read zero", rd_data, 8'h84);
    do_reset(1'b0, 1'b0, 1'b0);
    @(negedge bus_clk);
    chk("R2 por clears always-on", rd_data, 8'h00);
    chk("R8 cfg_lock low after por", {7'b0, cfg_lock}, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset_values();
    t_enable_handshake();
    t_busy_ignore();
    t_window_guard();
    t_always_on();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule